// File: doc/BRIEF.md
# Extended program-memory byte loader

This execution unit carries out a byte load from a program memory that is organized in 16-bit words. On a start strobe it decodes the instruction word and forms a 24-bit byte address. The upper 8 bits come from a page register and the lower 16 bits come from the pointer pair held in general registers 30 (low byte) and 31 (high byte). The unit reads the addressed word through a synchronous memory port with one cycle of read latency. Bit 0 of the byte address selects one byte of that word, and the unit writes the byte to the destination register through the register-file write port.

One encoding can also advance the pointer after the access. That increment treats page and pointer as a single 24-bit value, so a carry out of the pointer pair moves into the page register, and 0xFFFFFF wraps to zero. Every accepted instruction takes three cycles: address, data capture, then write-back. `done` marks the last of the three. The unit writes no status flags. Words it does not recognise, and the post-increment form aimed at the pointer's own registers, raise `illegal` and change nothing.

Top module: `pmem_byte_loader`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done`, `illegal`, `pm_rd_en`, `rf_we`, `rf_ptr_we` and `page_we` are all low.
- R2: Instruction word 0x95D8 loads the selected byte into register 0 and leaves pointer and page unwritten.
- R3: An instruction word with bits [15:9]=1001000 and bits [3:0]=0110 loads the selected byte into the register numbered by bits [8:4] and leaves pointer and page unwritten.
- R4: An instruction word with bits [15:9]=1001000 and bits [3:0]=0111 loads the selected byte into the register numbered by bits [8:4]. In the same cycle it writes back pointer+1 and page, with the increment applied to the 24-bit value {page, pointer}.
- R5: The byte address is {page, r31, r30}. In the first cycle after an accepted start, `pm_rd_en` is high and `pm_addr` equals the byte address shifted right by one.
- R6: A byte address with bit 0 = 0 returns bits [7:0] of the memory word, and one with bit 0 = 1 returns bits [15:8].
- R7: `busy` is high for exactly the three cycles after an accepted start. `done` and the write enables are high only in the third of those cycles, and `busy` is low in the following cycle.
- R8: A carry out of the 16-bit pointer increments the page, and the value 0xFFFFFF increments to 0x000000.
- R9: An unrecognised instruction word raises `illegal` for the one cycle after the start. It keeps `busy` low and causes no register, pointer or page write.
- R10: The post-increment form with destination 30 or 31 is treated as illegal: `illegal` rises and nothing is written.
- R11: A start strobe that arrives while `busy` is high is ignored. The running operation completes unchanged and no second operation follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Strobe: `instr` is valid this cycle |
| instr | input | 16 | Instruction word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Last cycle of an operation; write-back happens here |
| illegal | output | 1 | Rejected instruction (one-cycle pulse) |
| pm_rd_en | output | 1 | Program-memory read enable |
| pm_addr | output | 23 | Program-memory word address |
| pm_rdata | input | 16 | Program-memory word, one cycle after the read |
| rf_ptr_rdata | input | 16 | Current pointer pair {r31, r30} |
| rf_we | output | 1 | Destination register write enable |
| rf_waddr | output | 5 | Destination register index |
| rf_wdata | output | 8 | Loaded byte |
| rf_ptr_we | output | 1 | Pointer pair write enable |
| rf_ptr_wdata | output | 16 | Incremented pointer pair |
| page_rdata | input | 8 | Current page register |
| page_we | output | 1 | Page register write enable |
| page_wdata | output | 8 | Page after the carry from the increment |

## Verification
Counting from the clock edge that samples `start`, the memory address and read enable are due in the following cycle, the byte and the write enables two cycles later, and the updated registers one edge after that. `illegal` is due in the first cycle after the edge. The bench drives and samples on the falling edge. It checks the address in the first cycle and counts falling edges until `done`, expecting exactly three. It reads its register and page model only after the write edge. For rejected words it watches for three further cycles to confirm that no write enable ever fired.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
   localparam int REG_IDX_W = 5;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_ADDR,
      ST_DATA,
      ST_WB
   } lpm_state_e;

   typedef struct packed {
      logic                 valid;
      logic                 post_inc;
      logic [REG_IDX_W-1:0] dst;
   } lpm_op_t;
endpackage

// File: rtl/lpm_decode.sv
module lpm_decode
   import lpm_pkg::*;
#(
   parameter int INSTR_W    = 16,
   parameter bit PTR_INC_EN = 1'b1
) (
   input  logic [INSTR_W-1:0] instr,
   output lpm_op_t            op
);
   localparam logic [INSTR_W-1:0] IMPLIED_WORD = INSTR_W'(16'h95D8);

   if (INSTR_W != 16) begin : g_bad_instr_w
      $error("lpm_decode: INSTR_W must be 16");
   end

   logic is_implied;
   logic is_plain;
   logic is_inc_raw;
   logic inc_ok;

   always_comb begin
      is_implied = (instr == IMPLIED_WORD);
      is_plain   = (instr[15:9] == 7'b1001000) && (instr[3:0] == 4'b0110);
      is_inc_raw = (instr[15:9] == 7'b1001000) && (instr[3:0] == 4'b0111);
   end

   if (PTR_INC_EN) begin : g_inc_on
      // the pointer registers themselves may not be the target of the stepping form
      assign inc_ok = is_inc_raw && (instr[8:5] != 4'b1111);
   end else begin : g_inc_off
      assign inc_ok = 1'b0;
   end

   always_comb begin
      op.valid    = is_implied | is_plain | inc_ok;
      op.post_inc = inc_ok;
      op.dst      = is_implied ? '0 : instr[8:4];
   end
endmodule

// File: rtl/lpm_addr_inc.sv
module lpm_addr_inc #(
   parameter int PAGE_W    = 8,
   parameter int PTR_W     = 16,
   parameter bit SPLIT_INC = 1'b1
) (
   input  logic [PAGE_W-1:0] page_i,
   input  logic [PTR_W-1:0]  ptr_i,
   output logic [PAGE_W-1:0] page_o,
   output logic [PTR_W-1:0]  ptr_o
);
   localparam int FULL_W = PAGE_W + PTR_W;

   if (PAGE_W < 1 || PTR_W < 1) begin : g_bad_w
      $error("lpm_addr_inc: widths must be positive");
   end

   if (SPLIT_INC) begin : g_split
      logic ptr_carry;
      always_comb begin
         {ptr_carry, ptr_o} = {1'b0, ptr_i} + (PTR_W+1)'(1);
         page_o             = page_i + PAGE_W'(ptr_carry);
      end
   end else begin : g_flat
      always_comb begin
         {page_o, ptr_o} = {page_i, ptr_i} + FULL_W'(1);
      end
   end
endmodule

// File: rtl/lpm_byte_sel.sv
module lpm_byte_sel #(
   parameter int WORD_W = 16,
   localparam int LANES = WORD_W / 8,
   localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic [WORD_W-1:0] word_i,
   input  logic [SEL_W-1:0]  sel_i,
   output logic [7:0]        byte_o
);
   if (WORD_W % 8 != 0 || LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_word
      $error("lpm_byte_sel: WORD_W must be a power-of-two multiple of 8, at least 16");
   end

   logic [7:0] lanes [LANES];

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign lanes[i] = word_i[i*8 +: 8];
   end

   // R6: lane 0 holds the low byte, selected by an even byte address
   assign byte_o = lanes[sel_i];
endmodule

// File: rtl/pmem_byte_loader.sv
module pmem_byte_loader
   import lpm_pkg::*;
#(
   parameter int PAGE_W     = 8,
   parameter int PTR_W      = 16,
   parameter int WORD_W     = 16,
   parameter bit PTR_INC_EN = 1'b1,
   parameter bit SPLIT_INC  = 1'b1,
   localparam int BADDR_W   = PAGE_W + PTR_W,
   localparam int LANES     = WORD_W / 8,
   localparam int SEL_W     = (LANES > 1) ? $clog2(LANES) : 1,
   localparam int WADDR_W   = BADDR_W - SEL_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [15:0]          instr,
   output logic                 busy,
   output logic                 done,
   output logic                 illegal,
   output logic                 pm_rd_en,
   output logic [WADDR_W-1:0]   pm_addr,
   input  logic [WORD_W-1:0]    pm_rdata,
   input  logic [PTR_W-1:0]     rf_ptr_rdata,
   output logic                 rf_we,
   output logic [REG_IDX_W-1:0] rf_waddr,
   output logic [7:0]           rf_wdata,
   output logic                 rf_ptr_we,
   output logic [PTR_W-1:0]     rf_ptr_wdata,
   input  logic [PAGE_W-1:0]    page_rdata,
   output logic                 page_we,
   output logic [PAGE_W-1:0]    page_wdata
);
   if (PTR_W != 16) begin : g_bad_ptr
      $error("pmem_byte_loader: pointer pair must be 16 bits");
   end
   if (PAGE_W < 1) begin : g_bad_page
      $error("pmem_byte_loader: PAGE_W must be positive");
   end

   lpm_state_e         state_q;
   lpm_op_t            op_q;
   lpm_op_t            op_dec;
   logic [BADDR_W-1:0] baddr_cur;
   logic [BADDR_W-1:0] baddr_q;
   logic [7:0]         byte_sel;
   logic [7:0]         byte_q;
   logic               illegal_q;
   logic [PAGE_W-1:0]  page_nx;
   logic [PTR_W-1:0]   ptr_nx;

   lpm_decode #(
      .INSTR_W   (16),
      .PTR_INC_EN(PTR_INC_EN)
   ) u_dec (
      .instr(instr),
      .op   (op_dec)
   );

   // R5: page supplies the upper bits, pointer pair the lower bits
   assign baddr_cur = {page_rdata, rf_ptr_rdata};

   lpm_byte_sel #(
      .WORD_W(WORD_W)
   ) u_sel (
      .word_i(pm_rdata),
      .sel_i (baddr_q[SEL_W-1:0]),
      .byte_o(byte_sel)
   );

   lpm_addr_inc #(
      .PAGE_W   (PAGE_W),
      .PTR_W    (PTR_W),
      .SPLIT_INC(SPLIT_INC)
   ) u_inc (
      .page_i(baddr_q[BADDR_W-1:PTR_W]),
      .ptr_i (baddr_q[PTR_W-1:0]),
      .page_o(page_nx),
      .ptr_o (ptr_nx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         op_q      <= '0;
         baddr_q   <= '0;
         byte_q    <= '0;
         illegal_q <= 1'b0;
      end else begin
         illegal_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  if (op_dec.valid) begin
                     op_q    <= op_dec;
                     state_q <= ST_ADDR;
                  end else begin
                     illegal_q <= 1'b1;
                  end
               end
            end
            ST_ADDR: begin
               baddr_q <= baddr_cur;
               state_q <= ST_DATA;
            end
            ST_DATA: begin
               byte_q  <= byte_sel;
               state_q <= ST_WB;
            end
            ST_WB: begin
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      busy         = (state_q != ST_IDLE);
      done         = (state_q == ST_WB);
      illegal      = illegal_q;
      pm_rd_en     = (state_q == ST_ADDR);
      pm_addr      = baddr_cur[BADDR_W-1:SEL_W];
      rf_we        = done;
      rf_waddr     = op_q.dst;
      rf_wdata     = byte_q;
      rf_ptr_we    = done && op_q.post_inc;
      rf_ptr_wdata = ptr_nx;
      page_we      = done && op_q.post_inc;
      page_wdata   = page_nx;
   end

   // R7
   read_to_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pm_rd_en |-> ##2 done);

   // R7
   done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);

   // R9
   illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (!busy && !rf_we && !rf_ptr_we && !page_we));

   // R4
   ptr_page_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rf_ptr_we |-> (page_we && rf_we && done));

   // R11
   start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> (busy && !illegal));

   // R5
   single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pm_rd_en |=> !pm_rd_en);
endmodule

// File: tb/tb_pmem_byte_loader.sv
module tb_pmem_byte_loader;
   localparam time CLK_PERIOD = 10ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] instr = '0;
   logic        busy, done, illegal, pm_rd_en;
   logic [22:0] pm_addr;
   logic [15:0] pm_rdata;
   logic [15:0] rf_ptr_rdata;
   logic        rf_we, rf_ptr_we, page_we;
   logic [4:0]  rf_waddr;
   logic [7:0]  rf_wdata, page_wdata, page_rdata;
   logic [15:0] rf_ptr_wdata;

   logic [7:0]  regs [32];
   logic [7:0]  page_m;
   int          wr_cnt = 0;
   logic        pset = 1'b0;
   logic [7:0]  pset_page = '0;
   logic [15:0] pset_ptr = '0;
   logic [4:0]  pset_idx = '0;

   int total = 0;
   int fails = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pmem_byte_loader dut (
      .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
      .busy(busy), .done(done), .illegal(illegal),
      .pm_rd_en(pm_rd_en), .pm_addr(pm_addr), .pm_rdata(pm_rdata),
      .rf_ptr_rdata(rf_ptr_rdata),
      .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
      .rf_ptr_we(rf_ptr_we), .rf_ptr_wdata(rf_ptr_wdata),
      .page_rdata(page_rdata), .page_we(page_we), .page_wdata(page_wdata)
   );

   function automatic logic [15:0] mem_word(input logic [22:0] a);
      return {a[7:0] ^ 8'h5A, a[15:8] + {1'b0, a[22:16]} + 8'h03};
   endfunction

   function automatic logic [7:0] exp_byte(input logic [23:0] b);
      logic [15:0] w;
      w = mem_word(b[23:1]);
      return b[0] ? w[15:8] : w[7:0];
   endfunction

   assign rf_ptr_rdata = {regs[31], regs[30]};
   assign page_rdata   = page_m;

   // register file, page register and program memory model
   always @(posedge clk) begin
      if (pset) begin
         page_m   <= pset_page;
         regs[30] <= pset_ptr[7:0];
         regs[31] <= pset_ptr[15:8];
         if (pset_idx < 5'd30) regs[pset_idx] <= 8'hEE;
      end else begin
         if (rf_we) regs[rf_waddr] <= rf_wdata;
         if (rf_ptr_we) begin
            regs[30] <= rf_ptr_wdata[7:0];
            regs[31] <= rf_ptr_wdata[15:8];
         end
         if (page_we) page_m <= page_wdata;
         if (rf_we || rf_ptr_we || page_we) wr_cnt <= wr_cnt + 1;
      end
      if (pm_rd_en) pm_rdata <= mem_word(pm_addr);
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic preset(input logic [7:0] pg, input logic [15:0] p, input logic [4:0] idx);
      @(negedge clk);
      pset = 1'b1; pset_page = pg; pset_ptr = p; pset_idx = idx;
      @(negedge clk);
      pset = 1'b0;
   endtask

   task automatic do_load(input logic [15:0] iw, input logic [7:0] pg, input logic [15:0] p,
                          input bit poke, input string req);
      logic [23:0] ba, nb;
      logic [4:0]  d;
      bit          inc;
      int          n, wc;
      ba  = {pg, p};
      nb  = ba + 24'd1;
      d   = (iw == 16'h95D8) ? 5'd0 : iw[8:4];
      inc = (iw[3:0] == 4'b0111);
      preset(pg, p, d);
      wc = wr_cnt;
      @(negedge clk);
      start = 1'b1; instr = iw;
      @(negedge clk);
      start = 1'b0;
      // R5: address cycle
      check(pm_rd_en && busy, "R5 read enable in first cycle", {30'd0, pm_rd_en, busy}, 32'h3);
      check(pm_addr == ba[23:1], "R5 word address", {9'd0, pm_addr}, {9'd0, ba[23:1]});
      if (poke) begin
         start = 1'b1; instr = 16'h95D8;
      end
      n = 1;
      while (!done && n < 8) begin
         @(negedge clk);
         start = 1'b0;
         n++;
      end
      // R7: done in the third cycle
      check(n == 3, "R7 cycles to done", n, 3);
      @(negedge clk);
      check(!busy && !done, "R7 idle after done", {30'd0, busy, done}, 0);
      check(regs[d] == exp_byte(ba), req, regs[d], exp_byte(ba));
      if (inc) begin
         check({page_m, regs[31], regs[30]} == nb, "R4 R8 pointer after increment",
               {8'd0, page_m, regs[31], regs[30]}, {8'd0, nb});
      end else if (d < 5'd30) begin
         check({page_m, regs[31], regs[30]} == ba, "R2 R3 pointer unchanged",
               {8'd0, page_m, regs[31], regs[30]}, {8'd0, ba});
      end
      // R11: exactly one write-back cycle, no extra operation
      check(wr_cnt == wc + 1, "R11 single write-back", wr_cnt - wc, 1);
   endtask

   task automatic do_illegal(input logic [15:0] iw, input string req);
      int wc;
      preset(8'h44, 16'h5678, 5'd0);
      wc = wr_cnt;
      @(negedge clk);
      start = 1'b1; instr = iw;
      @(negedge clk);
      start = 1'b0;
      check(illegal && !busy, req, {30'd0, illegal, busy}, 32'h2);
      repeat (3) begin
         @(negedge clk);
         check(!busy && !illegal, {req, " quiet afterwards"}, {30'd0, busy, illegal}, 0);
      end
      check(wr_cnt == wc, {req, " no writes"}, wr_cnt - wc, 0);
      check({page_m, regs[31], regs[30]} == 24'h445678, {req, " pointer kept"},
            {8'd0, page_m, regs[31], regs[30]}, 32'h445678);
   endtask

   task automatic test_reset;
      repeat (2) @(negedge clk);
      check(!busy && !done && !illegal && !pm_rd_en && !rf_we && !rf_ptr_we && !page_we,
            "R1 outputs during reset", {25'd0, busy, done, illegal, pm_rd_en, rf_we, rf_ptr_we, page_we}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !done && !illegal && !pm_rd_en && !rf_we && !rf_ptr_we && !page_we,
            "R1 outputs after reset", {25'd0, busy, done, illegal, pm_rd_en, rf_we, rf_ptr_we, page_we}, 0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      total++; fails++;
      $display("FAIL R7 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      test_reset();
      do_load(16'h95D8, 8'h01, 16'h2345, 1'b0, "R2 R6 implied r0 high byte");
      do_load(16'h9106, 8'h00, 16'h1000, 1'b0, "R3 R6 r16 low byte");
      do_load(16'h9056, 8'h7A, 16'hBEEF, 1'b0, "R3 R6 r5 high byte");
      do_load(16'h9117, 8'h03, 16'h00FE, 1'b0, "R4 r17 step");
      do_load(16'h9147, 8'h12, 16'hFFFF, 1'b0, "R8 page carry");
      do_load(16'h9017, 8'hFF, 16'hFFFF, 1'b0, "R8 full wrap");
      do_load(16'h91E6, 8'h20, 16'h0102, 1'b0, "R3 load into r30");
      do_load(16'h9066, 8'h05, 16'h3333, 1'b1, "R11 busy start ignored");
      do_illegal(16'h91E7, "R10 step into r30");
      do_illegal(16'h91F7, "R10 step into r31");
      do_illegal(16'h0000, "R9 unknown word 0000");
      do_illegal(16'h9004, "R9 unknown word 9004");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule